// File: doc/BRIEF.md
# Rate-1/3 Turbo Encoder Datapath with Trellis Termination

The block turns a stream of information bits into rate-1/3 turbo code words. The caller presents, one pair per cycle, a bit of the block in natural order and the bit at the same position of the interleaved sequence. It raises a last flag with the final pair. Two identical 8-state recursive systematic encoders run in lockstep. Each accepted pair yields one 3-bit word that carries the systematic bit and the two parity bits.

After the last pair, the block drives each encoder back to the all-zero state in turn. For each encoder it runs three steps whose input is the encoder's own feedback. The twelve tail bits that this produces leave as four more 3-bit words, packed in a fixed interleaved order. A block of K information bits therefore gives K + 4 output words. Start-of-block and end-of-block markers frame the output. Both edges use a valid/ready handshake, and a stalled output freezes the encoders and the tail sequencer.

Top module: `turbo_enc_term`

## Requirements
- R1: While reset is held and right after it, `out_valid_o` is 0 and `in_ready_o` is 1.
- R2: Each accepted information pair k produces one output word. Bit 0 of that word is the natural-order bit X_k. `out_sob_o` is 1 on the word for k = 0.
- R3: Bit 1 of an information word is the parity Z_k of the first encoder, and bit 2 is the parity Z'_k of the second encoder. The second encoder is fed the interleaved bit. Each encoder has three delay cells d1 (newest), d2 and d3. Its feedback is d2^d3 (polynomial 1+D^2+D^3), and its stored value is a = input^d2^d3. Its parity is a^d1^d3 (polynomial 1+D+D^3). On each step the cells shift: d1 takes a, d2 takes d1, d3 takes d2.
- R4: After the last information word, the first encoder runs three tail steps while the second encoder holds its state. In each step the input equals the feedback, which gives tail bits X_K..X_K+2 and parities Z_K..Z_K+2. Word K is {bit2,bit1,bit0} = {X_K+1, Z_K, X_K}. Word K+1 is {Z_K+2, X_K+2, Z_K+1}.
- R5: Next, the second encoder runs three tail steps in the same way while the first encoder holds its state. Word K+2 is {X'_K+1, Z'_K, X'_K}. Word K+3 is {Z'_K+2, X'_K+2, Z'_K+1}.
- R6: A block of K bits gives exactly K + 4 words. `out_eob_o` is 1 only on word K+3, `out_sob_o` is 1 only on word 0, and no word carries both markers.
- R7: While `out_valid_o` is 1 and `out_ready_i` is 0, the word and its markers hold steady and nothing is lost or skipped.
- R8: `in_ready_o` is 0 from the cycle after the last pair is accepted until the final tail word has been loaded.
- R9: When the tail ends, both encoders are in the zero state. The next block, even one that follows at once, encodes as if from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input pair present |
| in_ready_o | output | 1 | Pair accepted this cycle if valid |
| sys_bit_i | input | 1 | Natural-order information bit |
| ilv_bit_i | input | 1 | Interleaved information bit |
| in_last_i | input | 1 | Marks the last pair of a block |
| out_valid_o | output | 1 | Output word present |
| out_ready_i | input | 1 | Downstream takes the word |
| out_bits_o | output | 3 | Code word, bit layout per R2 to R5 |
| out_sob_o | output | 1 | First word of a block |
| out_eob_o | output | 1 | Last word of a block |

## Verification
A wrong encoder state shows up on the very next information word, as a parity bit that differs from the polynomial model. A wrong state left behind by the tail shows up in the parity of the first words of the following block. A fault in the tail hold registers or in the step ordering corrupts one of the four tail words of the same block, within six cycles of the last input. Blocks of one to four bits are swept over every pattern of both input streams, back to back. Longer random blocks then run under random stalls on both edges.

// File: rtl/turbo_enc_pkg.sv
package turbo_enc_pkg;
  localparam int unsigned MEM     = 3;
  localparam int unsigned NUM_ENC = 2;
  localparam int unsigned WORD_W  = NUM_ENC + 1;
  localparam int unsigned SUB_W   = $clog2(MEM);
  localparam int unsigned IDX_W   = (NUM_ENC > 1) ? $clog2(NUM_ENC) : 1;
  // bit i = coefficient of D^i
  localparam logic [MEM:0] FB_POLY = 4'b1101;
  localparam logic [MEM:0] FF_POLY = 4'b1011;
endpackage

// File: rtl/tenc_rsc.sv
module tenc_rsc
  import turbo_enc_pkg::*;
#(
  parameter int unsigned M = MEM,
  parameter logic [M:0] FB = FB_POLY,
  parameter logic [M:0] FF = FF_POLY
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic term_i,
  input  logic bit_i,
  output logic sys_o,
  output logic par_o,
  output logic zero_o
);
  logic [M:1] d_q;
  logic fb, a;

  assign fb     = ^(d_q & FB[M:1]);
  assign sys_o  = term_i ? fb : bit_i;
  assign a      = sys_o ^ fb;
  assign par_o  = (a & FF[0]) ^ (^(d_q & FF[M:1]));
  assign zero_o = (d_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   d_q <= '0;
    else if (en_i) d_q <= {d_q[M-1:1], a};
  end
endmodule

// File: rtl/tenc_tail_seq.sv
module tenc_tail_seq
  import turbo_enc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              can_load_i,
  input  logic              x_i,
  input  logic              z_i,
  output logic              active_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              step_o,
  output logic              emit_o,
  output logic              last_o,
  output logic [WORD_W-1:0] bits_o
);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(MEM - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_ENC - 1);

  logic [SUB_W-1:0] sub_q;
  logic             h_x_q, h_z_q;

  assign emit_o = active_o && (sub_q != '0);
  assign step_o = active_o && (!emit_o || can_load_i);
  assign last_o = emit_o && (sub_q == SUB_LAST) && (idx_o == IDX_LAST);
  // step 1: {x1, z0, x0}; step 2: {z2, x2, z1}
  assign bits_o = (sub_q == SUB_W'(1)) ? {x_i, h_z_q, h_x_q} : {z_i, x_i, h_z_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      sub_q    <= '0;
      idx_o    <= '0;
    end else if (start_i) begin
      active_o <= 1'b1;
      sub_q    <= '0;
      idx_o    <= '0;
    end else if (step_o) begin
      if (sub_q == SUB_LAST) begin
        sub_q <= '0;
        if (idx_o == IDX_LAST) active_o <= 1'b0;
        else                   idx_o    <= idx_o + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_x_q <= 1'b0;
      h_z_q <= 1'b0;
    end else if (step_o) begin
      if (sub_q == '0) begin
        h_x_q <= x_i;
        h_z_q <= z_i;
      end else if (sub_q == SUB_W'(1)) begin
        h_z_q <= z_i;
      end
    end
  end
endmodule

// File: rtl/turbo_enc_term.sv
module turbo_enc_term
  import turbo_enc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              sys_bit_i,
  input  logic              ilv_bit_i,
  input  logic              in_last_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [WORD_W-1:0] out_bits_o,
  output logic              out_sob_o,
  output logic              out_eob_o
);
  logic               can_load, in_fire;
  logic               tail_active, tail_step, tail_emit, tail_last, tail_done;
  logic [IDX_W-1:0]   tail_idx;
  logic [WORD_W-1:0]  tail_bits;
  logic [NUM_ENC-1:0] enc_en, enc_din, enc_u, enc_z, enc_zero;
  logic               first_q;

  assign can_load   = !out_valid_o || out_ready_i;
  assign in_ready_o = can_load && !tail_active;
  assign in_fire    = in_valid_i && in_ready_o;
  assign tail_done  = tail_last && tail_step;
  assign enc_din    = {ilv_bit_i, sys_bit_i};

  for (genvar i = 0; i < NUM_ENC; i++) begin : g_enc
    assign enc_en[i] = in_fire || (tail_step && (tail_idx == IDX_W'(i)));
    tenc_rsc u_rsc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (enc_en[i]),
      .term_i (tail_active),
      .bit_i  (enc_din[i]),
      .sys_o  (enc_u[i]),
      .par_o  (enc_z[i]),
      .zero_o (enc_zero[i])
    );
  end

  tenc_tail_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (in_fire && in_last_i),
    .can_load_i (can_load),
    .x_i        (enc_u[tail_idx]),
    .z_i        (enc_z[tail_idx]),
    .active_o   (tail_active),
    .idx_o      (tail_idx),
    .step_o     (tail_step),
    .emit_o     (tail_emit),
    .last_o     (tail_last),
    .bits_o     (tail_bits)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_bits_o  <= '0;
      out_sob_o   <= 1'b0;
      out_eob_o   <= 1'b0;
    end else if (can_load) begin
      out_valid_o <= in_fire || (tail_step && tail_emit);
      if (in_fire) begin
        out_bits_o <= {enc_z[1], enc_z[0], sys_bit_i};
        out_sob_o  <= first_q;
        out_eob_o  <= 1'b0;
      end else if (tail_step && tail_emit) begin
        out_bits_o <= tail_bits;
        out_sob_o  <= 1'b0;
        out_eob_o  <= tail_last;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        first_q <= 1'b1;
    else if (in_fire)   first_q <= 1'b0;
    else if (tail_done) first_q <= 1'b1;
  end
endmodule

// File: rtl/turbo_enc_term_chk.sv
module turbo_enc_term_chk
  import turbo_enc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              sys_bit_i,
  input logic              in_last_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [WORD_W-1:0] out_bits_o,
  input logic              out_sob_o,
  input logic              out_eob_o,
  input logic              tail_done,
  input logic [NUM_ENC-1:0] enc_zero
);
  a_r2_sys_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o && out_bits_o[0] == $past(sys_bit_i));

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_bits_o)
      && $stable(out_sob_o) && $stable(out_eob_o));

  a_r8_tail_blocks_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && in_last_i |=> !in_ready_o);

  a_r6_markers_apart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(out_valid_o && out_sob_o && out_eob_o));

  a_r9_zero_after_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_done |=> &enc_zero);
endmodule

bind turbo_enc_term turbo_enc_term_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .sys_bit_i   (sys_bit_i),
  .in_last_i   (in_last_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_bits_o  (out_bits_o),
  .out_sob_o   (out_sob_o),
  .out_eob_o   (out_eob_o),
  .tail_done   (tail_done),
  .enc_zero    (enc_zero)
);

// File: tb/turbo_enc_term_test.sv
`timescale 1ns/100ps
module turbo_enc_term_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, sys_b = 1'b0, ilv_b = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, sob, eob;
  logic [2:0] bits;

  always #2.5 clk = ~clk;

  turbo_enc_term uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .sys_bit_i(sys_b), .ilv_bit_i(ilv_b), .in_last_i(in_last),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_bits_o(bits),
    .out_sob_o(sob), .out_eob_o(eob)
  );

  bit sys_q[$], ilv_q[$], last_q[$];
  logic [4:0] exp_q[$];
  string req_q[$];
  int checks = 0, fails = 0, sweep_len = 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_word(bit s, bit e, logic [2:0] b, string r);
    exp_q.push_back({s, e, b});
    req_q.push_back(r);
  endtask

  // s[0] newest cell; returns {z, x}
  function automatic logic [1:0] rsc_step(ref logic [2:0] s, input bit term, input bit u);
    logic fb, x, a, z;
    fb = s[1] ^ s[2];
    x  = term ? fb : u;
    a  = x ^ fb;
    z  = a ^ s[0] ^ s[2];
    s  = {s[1:0], a};
    return {z, x};
  endfunction

  task automatic add_block(int k, logic [63:0] sv, logic [63:0] iv);
    logic [2:0] s1 = 3'b0, s2 = 3'b0;
    logic [1:0] r1, r2;
    logic [1:0] t[3];
    for (int i = 0; i < k; i++) begin
      sys_q.push_back(sv[i]); ilv_q.push_back(iv[i]); last_q.push_back(i == k - 1);
      r1 = rsc_step(s1, 1'b0, sv[i]);
      r2 = rsc_step(s2, 1'b0, iv[i]);
      push_word(i == 0, 1'b0, {r2[1], r1[1], sv[i]}, "R2/R3/R9 info word");
    end
    for (int j = 0; j < 3; j++) t[j] = rsc_step(s1, 1'b1, 1'b0);
    push_word(1'b0, 1'b0, {t[1][0], t[0][1], t[0][0]}, "R4 tail word K");
    push_word(1'b0, 1'b0, {t[2][1], t[2][0], t[1][1]}, "R4 tail word K+1");
    for (int j = 0; j < 3; j++) t[j] = rsc_step(s2, 1'b1, 1'b0);
    push_word(1'b0, 1'b0, {t[1][0], t[0][1], t[0][0]}, "R5 tail word K+2");
    push_word(1'b0, 1'b1, {t[2][1], t[2][0], t[1][1]}, "R5 tail word K+3");
  endtask

  initial begin
    int in_idx = 0, cyc = 0;
    bit pend_last = 0, prev_stall = 0, bp;
    logic [4:0] prev_w = '0, e;
    string r;

    for (int k = 1; k <= 4; k++)
      for (int p = 0; p < (1 << (2 * k)); p++)
        add_block(k, 64'(p & ((1 << k) - 1)), 64'(p >> k));
    sweep_len = sys_q.size();
    for (int b = 0; b < 30; b++)
      add_block(5 + int'($urandom % 44), {$urandom, $urandom}, {$urandom, $urandom});

    repeat (3) @(negedge clk);
    check(!out_valid && in_ready, "R1 reset state", {out_valid, in_ready}, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R1 after reset", {out_valid, in_ready}, 2'b01);

    while (exp_q.size() > 0 && cyc < 150000) begin
      @(negedge clk);
      cyc++;
      bp = in_idx >= sweep_len;
      out_ready = bp ? ($urandom % 4 != 0) : 1'b1;
      if (in_idx < sys_q.size()) begin
        in_valid = bp ? ($urandom % 3 != 0) : 1'b1;
        sys_b = sys_q[in_idx]; ilv_b = ilv_q[in_idx]; in_last = last_q[in_idx];
      end else begin
        in_valid = 1'b0; in_last = 1'b0;
      end
      #1;
      if (pend_last) begin
        check(!in_ready, "R8 input blocked in tail", in_ready, 0);
        pend_last = 0;
      end
      if (prev_stall)
        check(out_valid && {sob, eob, bits} == prev_w, "R7 stalled word held",
              {out_valid, sob, eob, bits}, {1'b1, prev_w});
      prev_stall = out_valid && !out_ready;
      prev_w = {sob, eob, bits};
      if (in_valid && in_ready) begin
        if (in_last) pend_last = 1;
        in_idx++;
      end
      if (out_valid && out_ready) begin
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(bits == e[2:0], r, bits, e[2:0]);
        check({sob, eob} == e[4:3], "R6 block markers", {sob, eob}, e[4:3]);
      end
    end
    if (cyc >= 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: %0d words outstanding", exp_q.size());
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (10) @(negedge clk);
    check(!out_valid, "R6 no extra words", out_valid, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule